// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block produces one pulse-width modulated waveform from an 8-bit counter, a period value and a duty value. The counter advances once per channel-clock tick (`clk_en` high for one system clock). It runs either as a wrapping up-counter (left alignment) or as an up/down counter (center alignment). The output sits at its start level while the counter is below the duty value and at the opposite level otherwise.

Period and duty are held twice. A software-visible buffer takes every write. An active copy feeds the comparator, and while the channel runs it is refreshed from the buffer only at a period boundary or on a counter write. A waveform is therefore always wholly old or wholly new. While the channel is off, the active copy tracks the buffer directly.

The register map uses `wr_addr`/`rd_addr` values 0 (period), 1 (duty) and 2 (counter). A read returns its value on `rd_data` one clock after `rd_addr` is set.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: After reset the period reads 0xFF, the duty reads 0x00 and the counter reads 0. With the channel disabled, `pwm_o` shows the idle level one clock later.
- R2: In left alignment (`center_mode`=0) with active period P≥1, the counter steps 0,1,…,P-1,0 on successive ticks, so one output cycle lasts P ticks. After each tick, `pwm_o` equals the start level when the new count is below the active duty, and the other level otherwise.
- R3: In center alignment (`center_mode`=1) the counter climbs from 0 to P and then descends to 0, so one output cycle lasts 2·P ticks. It uses the same count-below-duty output rule as R2.
- R4: `pol_high`=1 makes the start level 1; `pol_high`=0 makes it 0. The idle level is the inverse of the start level, and a disabled channel drives it one clock after `ch_en` is low.
- R5: While enabled, a period or duty write leaves the active value unchanged until the counter next returns to 0 through a tick (left: wrap after P-1; center: end of the down-count).
- R6: A write to address 2 (data ignored) sets the counter to 0 and immediately loads the buffered period and duty into the active copies. The output is re-evaluated for count 0 on the same clock.
- R7: While disabled, period and duty writes reach both the buffer and the active copy. On re-enable the counter starts from 0 with the latest buffered values.
- R8: Reading address 0 or 1 returns the last value written there, even while a different value is active.
- R9: An active duty of 0 keeps `pwm_o` at the inactive level for the whole cycle. A duty above the highest count reached (P-1 left, P center) keeps it at the start level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Channel-clock tick, one system clock wide |
| ch_en | input | 1 | Channel enable |
| center_mode | input | 1 | 0 = left alignment, 1 = center alignment |
| pol_high | input | 1 | Start level of each output cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 period, 1 duty, 2 counter |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 period, 1 duty, 2 counter |
| rd_data | output | 8 | Registered read data |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The output is registered, so a tick, a counter write or a change of `ch_en` shows on `pwm_o` one clock after the edge that accepts it. Read data also arrives one clock after `rd_addr` is set. The bench changes inputs on the falling edge, lets exactly one rising edge take them, and samples on the following falling edge. Buffered-value cases count ticks from a known counter position, so each check falls either just before or just after the period boundary at which the new value becomes active.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  typedef enum logic [1:0] {
    ADR_PERIOD = 2'd0,
    ADR_DUTY   = 2'd1,
    ADR_COUNT  = 2'd2
  } adr_e;
endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         ld,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] per_buf,
  output logic [W-1:0] duty_buf,
  output logic [W-1:0] per_act,
  output logic [W-1:0] duty_nxt
);
  logic [W-1:0] duty_act;
  logic [W-1:0] per_buf_nxt, duty_buf_nxt, per_nxt;
  logic         take;

  always_comb begin
    per_buf_nxt  = per_buf;
    duty_buf_nxt = duty_buf;
    if (wr_en && wr_addr == ADR_PERIOD) per_buf_nxt  = wr_data;
    if (wr_en && wr_addr == ADR_DUTY)   duty_buf_nxt = wr_data;
    take     = !en || ld;
    per_nxt  = take ? per_buf_nxt  : per_act;
    duty_nxt = take ? duty_buf_nxt : duty_act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_buf  <= '1;
      duty_buf <= '0;
      per_act  <= '1;
      duty_act <= '0;
    end else begin
      per_buf  <= per_buf_nxt;
      duty_buf <= duty_buf_nxt;
      per_act  <= per_nxt;
      duty_act <= duty_nxt;
    end
  end

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !ld) |=> ($stable(per_act) && $stable(duty_act)));

  assert_off_follow_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (per_act == per_buf && duty_act == duty_buf));
endmodule

// File: rtl/pwm_dbuf_cnt.sv
module pwm_dbuf_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic         center,
  input  logic         cnt_wr,
  input  logic [W-1:0] per_act,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         ld,
  output logic         upd
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W:0]   ONEX = {{W{1'b0}}, 1'b1};

  logic       up_q, up_nxt;
  logic [W:0] inc;

  always_comb begin
    cnt_nxt = cnt_q;
    up_nxt  = up_q;
    ld      = 1'b0;
    inc     = {1'b0, cnt_q} + ONEX;
    if (!en) begin
      cnt_nxt = '0;
      up_nxt  = 1'b1;
    end else if (cnt_wr) begin
      cnt_nxt = '0;
      up_nxt  = 1'b1;
      ld      = 1'b1;
    end else if (tick) begin
      if (!center) begin
        up_nxt = 1'b1;
        if (inc >= {1'b0, per_act}) begin
          cnt_nxt = '0;
          ld      = 1'b1;
        end else begin
          cnt_nxt = inc[W-1:0];
        end
      end else if (up_q) begin
        if (cnt_q >= per_act) begin
          if (cnt_q <= ONE) begin
            cnt_nxt = '0;
            ld      = 1'b1;
          end else begin
            cnt_nxt = cnt_q - ONE;
            up_nxt  = 1'b0;
          end
        end else begin
          cnt_nxt = inc[W-1:0];
        end
      end else begin
        if (cnt_q <= ONE) begin
          cnt_nxt = '0;
          up_nxt  = 1'b1;
          ld      = 1'b1;
        end else begin
          cnt_nxt = cnt_q - ONE;
        end
      end
    end
    upd = en && (tick || cnt_wr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      up_q  <= up_nxt;
    end
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= per_act);

  assert_left_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !cnt_wr && !center && per_act != '0 && {1'b0, cnt_q} + ONEX == {1'b0, per_act})
    |=> cnt_q == '0);
endmodule

// File: rtl/pwm_dbuf_out.sv
module pwm_dbuf_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         upd,
  input  logic         pol,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] duty_nxt,
  output logic         pwm_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o <= 1'b0;
    end else if (!en) begin
      pwm_o <= ~pol;
    end else if (upd) begin
      pwm_o <= (cnt_nxt < duty_nxt) ? pol : ~pol;
    end
  end

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pwm_o == !$past(pol)));
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
  import pwm_dbuf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clk_en,
  input  logic         ch_en,
  input  logic         center_mode,
  input  logic         pol_high,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         pwm_o
);
  logic [W-1:0] per_buf, duty_buf, per_act, duty_nxt, cnt_q, cnt_nxt;
  logic         ld, upd, cnt_wr;

  assign cnt_wr = wr_en && (wr_addr == ADR_COUNT);

  pwm_dbuf_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .en(ch_en), .ld(ld),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .per_buf(per_buf), .duty_buf(duty_buf),
    .per_act(per_act), .duty_nxt(duty_nxt)
  );

  pwm_dbuf_cnt #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .en(ch_en), .tick(clk_en),
    .center(center_mode), .cnt_wr(cnt_wr), .per_act(per_act),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .ld(ld), .upd(upd)
  );

  pwm_dbuf_out #(.W(W)) u_out (
    .clk(clk), .rst(rst), .en(ch_en), .upd(upd), .pol(pol_high),
    .cnt_nxt(cnt_nxt), .duty_nxt(duty_nxt), .pwm_o(pwm_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADR_PERIOD: rd_data <= per_buf;
        ADR_DUTY:   rd_data <= duty_buf;
        ADR_COUNT:  rd_data <= cnt_q;
        default:    rd_data <= '0;
      endcase
    end
  end

  assert_cnt_write_zero_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> cnt_q == '0);
endmodule

// File: tb/pwm_dbuf_chan_tb.sv
module pwm_dbuf_chan_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b0, ch_en = 1'b0, center_mode = 1'b0, pol_high = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       pwm_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pwm_dbuf_chan u_dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .ch_en(ch_en),
    .center_mode(center_mode), .pol_high(pol_high),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
  );

  // {center, pol, period, duty}
  localparam logic [17:0] VECS [7] = '{
    {1'b0, 1'b1, 8'd4, 8'd2},
    {1'b0, 1'b0, 8'd5, 8'd3},
    {1'b1, 1'b1, 8'd4, 8'd2},
    {1'b1, 1'b0, 8'd3, 8'd1},
    {1'b0, 1'b1, 8'd6, 8'd0},
    {1'b0, 1'b1, 8'd3, 8'd7},
    {1'b1, 1'b1, 8'd2, 8'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    v = rd_data;
  endtask

  task automatic tick();
    clk_en = 1'b1;
    @(posedge clk); @(negedge clk);
    clk_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 period", v, 8'hFF);
    rd(2'd1, v); chk("R1 duty", v, 0);
    rd(2'd2, v); chk("R1 count", v, 0);
    chk("R1 idle out", pwm_o, 0);
    pol_high = 1'b0; @(negedge clk); @(negedge clk);
    chk("R4 idle out pol0", pwm_o, 1);

    // Vector table: R2 R3 R4 R9
    for (int i = 0; i < 7; i++) begin
      automatic logic c = VECS[i][17];
      automatic logic p = VECS[i][16];
      automatic int   per = VECS[i][15:8];
      automatic int   dty = VECS[i][7:0];
      automatic int   len = c ? 2 * per : per;
      automatic int   bad = 0;
      ch_en = 1'b0; center_mode = c; pol_high = p;
      @(negedge clk);
      wr(2'd0, VECS[i][15:8]);
      wr(2'd1, VECS[i][7:0]);
      ch_en = 1'b1;
      @(negedge clk);
      for (int k = 1; k <= 2 * len; k++) begin
        automatic int pos = k % len;
        automatic int cv = (c && pos > per) ? 2 * per - pos : pos;
        automatic logic e = (cv < dty) ? p : ~p;
        tick();
        if (pwm_o !== e) bad++;
      end
      chk($sformatf("R2/R3/R4/R9 vector %0d mismatches", i), bad, 0);
    end

    // R5 / R8: buffered duty while enabled
    ch_en = 1'b0; center_mode = 1'b0; pol_high = 1'b1;
    @(negedge clk);
    wr(2'd0, 8'd4); wr(2'd1, 8'd1);
    ch_en = 1'b1; @(negedge clk);
    tick();                              // count 1
    wr(2'd1, 8'd3);
    rd(2'd1, v); chk("R8 duty readback", v, 3);
    tick(); chk("R5 old duty kept", pwm_o, 0);      // count 2
    ticks(2);                            // count 3, 0 (load)
    tick(); chk("R5 new duty at boundary", pwm_o, 1); // count 1
    // R5: buffered period
    wr(2'd0, 8'd6);
    rd(2'd0, v); chk("R8 period readback", v, 6);
    ticks(3);
    rd(2'd2, v); chk("R5 old period wraps", v, 0);
    ticks(5);
    rd(2'd2, v); chk("R5 new period active", v, 5);

    // R6: counter write reloads immediately
    wr(2'd1, 8'd0);
    wr(2'd2, 8'h5A);
    chk("R6 output reloaded", pwm_o, 0);
    rd(2'd2, v); chk("R6 count zero", v, 0);

    // R7: disable loads buffered values; disabled writes are direct
    wr(2'd1, 8'd5);
    ch_en = 1'b0; @(negedge clk);
    chk("R4 idle on disable", pwm_o, 0);
    ch_en = 1'b1; @(negedge clk);
    ticks(4);
    chk("R7 duty loaded on disable", pwm_o, 1);
    ch_en = 1'b0; @(negedge clk);
    wr(2'd0, 8'd3);
    ch_en = 1'b1; @(negedge clk);
    ticks(3);
    rd(2'd2, v); chk("R7 period direct when off", v, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule